// File: doc/BRIEF.md
# Two-Modulus Prescaler Divide Control

This block is the programmable feedback divider of a synthesizer loop that uses a two-modulus prescaler dividing by 80 or 81. It runs on the prescaler's output clock. Each rising edge of that clock is one prescaler pulse. The block steers the prescaler modulus so that the oscillator is divided by `N*80 + A` overall. Once per divide period it emits a single-cycle pulse for the phase comparator.

The tuning values arrive as two packed bytes. The main-count byte omits a ninth bit that is always 1, so the main count is the byte plus 256. The swallow-count byte carries a flag in its top bit, which is discarded, so the swallow count is the low seven bits. Each byte has its own load strobe. A load is always accepted in the cycle its strobe is high, because the block applies no back-pressure on these inputs. An accepted value is held in a staging register and is applied to the divider only at the next period boundary. A value outside the legal range is refused and raises an error flag.

Top module: `dmd_divctl`

## Requirements
- R1: Between consecutive `div_out` pulses the oscillator-side count equals `N*80 + A`. That count is the sum over the prescaler cycles of 81 where `mod_hi` is 1 and 80 where it is 0.
- R2: The main count decodes as N = `n_byte` + 256, so bit 8 of N is always 1. For example, byte 0x87 gives N = 391.
- R3: The swallow count decodes as A = `a_byte[6:0]`. Bit 7 of `a_byte` has no effect. For example, byte 0xB2 gives A = 50.
- R4: In each period `mod_hi` is 1 (divide by 81) for the first A prescaler cycles and 0 (divide by 80) for the remaining N-A cycles.
- R5: `div_out` is high for exactly one prescaler cycle, namely the last cycle of each N-cycle period.
- R6: A byte accepted during a period does not change that period. It governs the periods that start after the following `div_out` pulse.
- R7: An `a_byte` load with A > 79 is refused, and the earlier A is kept. `cfg_err` reads 1 from the next cycle.
- R8: An `n_byte` load whose N lies outside 381..448 (byte outside 125..192) is refused, and the earlier N is kept. `cfg_err` reads 1 from the next cycle.
- R9: A load in which no byte is refused clears `cfg_err` on the next cycle.
- R10: After reset, N = 391, A = 50 and `cfg_err` = 0. `mod_hi` is 1 and `div_out` is 0 before the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; one edge per prescaler pulse |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_byte | input | 8 | Packed swallow-count byte |
| a_load | input | 1 | Load strobe for `a_byte` |
| n_byte | input | 8 | Packed main-count byte |
| n_load | input | 1 | Load strobe for `n_byte` |
| mod_hi | output | 1 | Modulus select: 1 = divide by 81, 0 = divide by 80 |
| div_out | output | 1 | One-cycle pulse ending each divide period |
| cfg_err | output | 1 | Last load contained a refused byte |

## Verification
A corrupt cycle counter or a wrong active value shows within one divide period, which is at most 448 prescaler cycles. It appears as a wrong spacing between `div_out` pulses or a wrong length of the `mod_hi` high run. Staging faults, such as a value applied early or a refused byte that leaks through, show as a changed ratio in the period that is in flight or in the next one. The bench sweeps every swallow count at the lowest main count and sweeps main counts across the full legal range, including both limits. For each setting it compares the period length, the high-run length and the oscillator-side total against arithmetic done in the bench.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SW_W    = 7;
  localparam int unsigned MAIN_W  = 9;
  localparam int unsigned LO_MOD  = 80;
  localparam int unsigned SW_MAX  = 79;
  localparam int unsigned MAIN_MIN = 381;
  localparam int unsigned MAIN_MAX = 448;

  typedef struct packed {
    logic [SW_W-1:0]   sw;
    logic [MAIN_W-1:0] main;
  } tune_t;
endpackage

// File: rtl/dmd_decode.sv
module dmd_decode
  import dmd_pkg::*;
(
  input  logic [BYTE_W-1:0] a_byte,
  input  logic [BYTE_W-1:0] n_byte,
  output tune_t             dec,
  output logic              sw_ok,
  output logic              main_ok
);
  always_comb begin
    dec.sw   = a_byte[SW_W-1:0];
    dec.main = {1'b1, n_byte};
    sw_ok    = (32'(dec.sw) <= SW_MAX);
    main_ok  = (32'(dec.main) >= MAIN_MIN) && (32'(dec.main) <= MAIN_MAX);
  end
endmodule

// File: rtl/dmd_shadow.sv
module dmd_shadow
  import dmd_pkg::*;
#(
  parameter int unsigned RST_MAIN = 391,
  parameter int unsigned RST_SW   = 50
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_load,
  input  logic  n_load,
  input  tune_t dec,
  input  logic  sw_ok,
  input  logic  main_ok,
  input  logic  boundary,
  output tune_t active,
  output logic  cfg_err
);
  tune_t staged;
  logic  bad_sw, bad_main;

  assign bad_sw   = a_load && !sw_ok;
  assign bad_main = n_load && !main_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged.sw   <= SW_W'(RST_SW);
      staged.main <= MAIN_W'(RST_MAIN);
      active.sw   <= SW_W'(RST_SW);
      active.main <= MAIN_W'(RST_MAIN);
      cfg_err     <= 1'b0;
    end else begin
      if (a_load && sw_ok)   staged.sw   <= dec.sw;
      if (n_load && main_ok) staged.main <= dec.main;
      if (boundary)          active      <= staged;
      if (bad_sw || bad_main)     cfg_err <= 1'b1;
      else if (a_load || n_load)  cfg_err <= 1'b0;
    end
  end

  AST_SW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sw |=> staged.sw == $past(staged.sw)); // R7
  AST_MAIN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_main |=> staged.main == $past(staged.main)); // R8
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_sw || bad_main) |=> cfg_err); // R7
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active)); // R6
  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(active.main) >= MAIN_MIN && 32'(active.main) <= MAIN_MAX
    && 32'(active.sw) <= SW_MAX); // R8
endmodule

// File: rtl/dmd_swallow_cnt.sv
module dmd_swallow_cnt
  import dmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tune_t active,
  output logic  mod_hi,
  output logic  boundary
);
  logic [MAIN_W-1:0] cnt;

  assign boundary = (cnt == active.main - MAIN_W'(1));
  assign mod_hi   = (cnt < MAIN_W'(active.sw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (boundary) cnt <= '0;
    else               cnt <= cnt + MAIN_W'(1);
  end

  AST_CNT_BELOW_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < active.main); // R5
  AST_WRAP_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> cnt == '0); // R5
  AST_HI_ENDS_AT_SW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> cnt == MAIN_W'(active.sw)); // R4
endmodule

// File: rtl/dmd_divctl.sv
module dmd_divctl
  import dmd_pkg::*;
#(
  parameter int unsigned RST_MAIN = 391,
  parameter int unsigned RST_SW   = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] a_byte,
  input  logic              a_load,
  input  logic [BYTE_W-1:0] n_byte,
  input  logic              n_load,
  output logic              mod_hi,
  output logic              div_out,
  output logic              cfg_err
);
  tune_t dec, active;
  logic  sw_ok, main_ok, boundary;

  dmd_decode u_dec (
    .a_byte (a_byte),
    .n_byte (n_byte),
    .dec    (dec),
    .sw_ok  (sw_ok),
    .main_ok(main_ok)
  );

  dmd_shadow #(.RST_MAIN(RST_MAIN), .RST_SW(RST_SW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_load  (a_load),
    .n_load  (n_load),
    .dec     (dec),
    .sw_ok   (sw_ok),
    .main_ok (main_ok),
    .boundary(boundary),
    .active  (active),
    .cfg_err (cfg_err)
  );

  dmd_swallow_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .mod_hi  (mod_hi),
    .boundary(boundary)
  );

  assign div_out = boundary;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out); // R5
  AST_GOOD_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_load && sw_ok && !(n_load && !main_ok)) ||
     (n_load && main_ok && !(a_load && !sw_ok))) |=> !cfg_err); // R9
endmodule

// File: tb/dmd_divctl_test.sv
module dmd_divctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_byte = 8'h00, n_byte = 8'h00;
  logic       a_load = 1'b0, n_load = 1'b0;
  logic       mod_hi, div_out, cfg_err;
  int tests = 0, fails = 0;
  int cur_n = 391, cur_a = 50;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmd_divctl uut (
    .clk(clk), .rst_n(rst_n), .a_byte(a_byte), .a_load(a_load),
    .n_byte(n_byte), .n_load(n_load), .mod_hi(mod_hi),
    .div_out(div_out), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_out);
  endtask

  // Measure one period starting after a pulse; optional load at cycle load_at.
  task automatic measure(output int cyc, output int hi, output int vco,
                         input int load_at, input logic [7:0] ab, input logic [7:0] nb);
    cyc = 0; hi = 0; vco = 0;
    do begin
      @(negedge clk);
      a_load = 1'b0; n_load = 1'b0;
      cyc++;
      hi  += int'(mod_hi);
      vco += mod_hi ? 81 : 80;
      if (cyc == load_at) begin
        a_byte = ab; n_byte = nb; a_load = 1'b1; n_load = 1'b1;
      end
    end while (!div_out && cyc < 1000);
  endtask

  task automatic load(input logic [7:0] ab, input bit la, input logic [7:0] nb, input bit ln);
    @(negedge clk);
    a_byte = ab; n_byte = nb; a_load = la; n_load = ln;
    @(negedge clk);
    a_load = 1'b0; n_load = 1'b0;
  endtask

  task automatic run_setting(input int n, input int a, input bit flag);
    int cyc, hi, vco;
    load(8'((flag ? 128 : 0) + a), 1'b1, 8'(n - 256), 1'b1);
    wait_pulse();
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R5 period length", cyc, n);
    check("R4 mod_hi run", hi, a);
    check("R1 ratio", vco, n * 80 + a);
  endtask

  initial begin
    int cyc, hi, vco;
    repeat (3) @(negedge clk);
    // R10 reset state before first active edge
    check("R10 mod_hi at reset", int'(mod_hi), 1);
    check("R10 div_out at reset", int'(div_out), 0);
    check("R10 cfg_err at reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    wait_pulse();
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R10 default period", cyc, 391);
    check("R10 default ratio", vco, 31330);

    // R2 R3 packed example bytes 0x87 / 0xB2 -> 391, 50 -> 31330
    load(8'hB2, 1'b1, 8'h87, 1'b1);
    wait_pulse();
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R2 main decode 0x87", cyc, 391);
    check("R3 swallow decode 0xB2", hi, 50);

    // R3: MSB of a_byte clear gives same A; sweep every A at lowest N
    for (int a = 0; a <= 79; a++) run_setting(381, a, a[0]);
    // R2/R1: N sweep across full range including both limits
    for (int n = 381; n <= 448; n += 4) run_setting(n, 79, 1'b1);
    run_setting(448, 0, 1'b1);
    run_setting(448, 79, 1'b0);

    // R6: load mid-period; in-flight period keeps old ratio (448,79)
    wait_pulse();
    measure(cyc, hi, vco, 20, 8'(128 + 10), 8'(400 - 256));
    check("R6 in-flight period unchanged", vco, 448 * 80 + 79);
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R6 next period uses new", vco, 400 * 80 + 10);

    // R7: A = 80 refused, error flagged, ratio kept
    load(8'd80, 1'b1, 8'h0, 1'b0);
    check("R7 cfg_err after bad A", int'(cfg_err), 1);
    wait_pulse();
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R7 A kept", hi, 10);
    check("R7 ratio kept", vco, 400 * 80 + 10);

    // R9: good load clears
    load(8'd200, 1'b1, 8'h0, 1'b0);  // 200 & 0x7F = 72
    check("R9 cfg_err cleared", int'(cfg_err), 0);
    wait_pulse();
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R3 MSB dropped 200->72", hi, 72);

    // R8: N = 380 and N = 449 refused
    load(8'h0, 1'b0, 8'd124, 1'b1);
    check("R8 cfg_err after N=380", int'(cfg_err), 1);
    load(8'h0, 1'b0, 8'd193, 1'b1);
    check("R8 cfg_err after N=449", int'(cfg_err), 1);
    wait_pulse();
    measure(cyc, hi, vco, -1, 8'h0, 8'h0);
    check("R8 N kept", cyc, 400);
    check("R8 ratio kept", vco, 400 * 80 + 72);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule